// File: doc/BRIEF.md
# Palette Colour Lookup with Host Register Port

This block holds a 256-entry colour table and serves it from two sides. A host reaches it through a synchronous register strobe port. One register sets where component writes go, and another sets where component reads come from. A third register is a mask applied to pixel indices. A single data register carries one 8-bit colour component per access, and a status register tells whether the data port was last pointed at writing or at reading. Components always travel in red, green, blue order. Writes are staged and land in the table only when the blue byte arrives, so a half-written entry is never visible.

On the pixel side, an 8-bit index arrives every cycle. It is ANDed with the mask and looked up, and one clock later the result appears as a packed 32-bit word with an opaque alpha byte on top. A sticky change flag goes high whenever an entry is committed, so a consumer can tell when the table has changed. The consumer clears the flag with a strobe.

Top module: `pal_dac`

## Requirements
- R1: After reset the write index and read index are 0, the mask is 0xFF, status reads 0x00, the change flag is low, and every table entry is zero, so a lookup returns 0xFF000000.
- R2: Register selects are 0 = write index, 1 = read index, 2 = data, 3 = mask, 4 = status. Write index, read index and mask read back the last value written to them. A read returns its value on `reg_rdata_o` after the clock edge that samples the strobe.
- R3: Three data writes in a row store red, green and blue, in that order, into the entry named by the write index. The entry changes only on the third write, and the write index then increments by one.
- R4: The write index wraps from 255 to 0 after a commit.
- R5: Three data reads in a row return red, green and blue of the entry named by the read index, and the read index then increments by one, wrapping from 255 to 0.
- R6: Writing either index register restarts the component sequence at red, and a partially written triplet is discarded.
- R7: Status bit 0 reads 1 after the write index was last written and 0 after the read index was last written. All other status bits read 0.
- R8: `pix_rgb_o` equals {0xFF, red, green, blue} of the entry at (`pix_idx_i` AND mask), one clock after the index is presented.
- R9: The change flag is set by every commit and cleared by `dirty_clr_i`. When both happen in the same cycle, the set wins.
- R10: Writes to selects 5 to 7 change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| pix_idx_i | input | 8 | Pixel index |
| pix_rgb_o | output | 32 | Packed colour, alpha in bits 31:24 |
| dirty_clr_i | input | 1 | Clears the change flag |
| dirty_o | output | 1 | Change flag |

## Verification
Two things can land in the same cycle: a triplet commit, which sets the change flag, and a clear strobe, which drops it. The bench issues the blue write together with `dirty_clr_i` and expects the flag to remain high. A following clear on its own must then bring the flag low. A pixel lookup of an entry that is being committed in that same cycle returns the old contents, and the bench checks that the new value appears only on the next lookup.

// File: rtl/pal_dac_pkg.sv
package pal_dac_pkg;
  typedef enum logic [2:0] {
    SEL_WIDX = 3'd0,
    SEL_RIDX = 3'd1,
    SEL_DATA = 3'd2,
    SEL_MASK = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/pal_dac_table.sv
module pal_dac_table #(
  parameter int IDX_W = 8,
  parameter int DW    = 8,
  localparam int ENTRIES = 1 << IDX_W,
  localparam int ENT_W   = 3 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_a_i,
  output logic [ENT_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0] raddr_b_i,
  output logic [ENT_W-1:0] rdata_b_o
);
  logic [ENT_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/pal_dac_host.sv
module pal_dac_host
  import pal_dac_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DW    = 8,
  localparam int ENT_W = 3 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             dirty_clr_i,
  output logic             dirty_o,
  input  logic [ENT_W-1:0] rd_entry_i,
  output logic [IDX_W-1:0] widx_o,
  output logic [IDX_W-1:0] ridx_o,
  output logic [DW-1:0]    mask_o,
  output logic             wr_mode_o,
  output logic             commit_o,
  output logic [ENT_W-1:0] commit_data_o
);
  logic [IDX_W-1:0] widx_q, ridx_q;
  logic [DW-1:0]    mask_q, rdata_q;
  logic [1:0]       comp_q;
  logic [DW-1:0]    stage_q [2];
  logic             wr_mode_q, dirty_q;
  logic             wr_acc, rd_acc, last_comp;
  logic [DW-1:0]    comp_byte, rd_mux;

  assign wr_acc    = en_i && we_i;
  assign rd_acc    = en_i && !we_i;
  assign last_comp = (comp_q == 2'd2);
  assign commit_o  = wr_acc && (sel_i == SEL_DATA) && last_comp;
  assign commit_data_o = {stage_q[0], stage_q[1], wdata_i};

  always_comb begin
    case (comp_q)
      2'd0:    comp_byte = rd_entry_i[3*DW-1:2*DW];
      2'd1:    comp_byte = rd_entry_i[2*DW-1:DW];
      default: comp_byte = rd_entry_i[DW-1:0];
    endcase
  end

  always_comb begin
    rd_mux = '0;
    case (sel_i)
      SEL_WIDX: rd_mux = DW'(widx_q);
      SEL_RIDX: rd_mux = DW'(ridx_q);
      SEL_DATA: rd_mux = comp_byte;
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = DW'(wr_mode_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q     <= '0;
      ridx_q     <= '0;
      mask_q     <= '1;
      comp_q     <= '0;
      stage_q[0] <= '0;
      stage_q[1] <= '0;
      wr_mode_q  <= 1'b0;
      dirty_q    <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (commit_o)         dirty_q <= 1'b1;
      else if (dirty_clr_i) dirty_q <= 1'b0;

      if (wr_acc) begin
        case (sel_i)
          SEL_WIDX: begin
            widx_q    <= wdata_i[IDX_W-1:0];
            comp_q    <= '0;
            wr_mode_q <= 1'b1;
          end
          SEL_RIDX: begin
            ridx_q    <= wdata_i[IDX_W-1:0];
            comp_q    <= '0;
            wr_mode_q <= 1'b0;
          end
          SEL_DATA: begin
            if (last_comp) begin
              widx_q <= widx_q + 1'b1;
              comp_q <= '0;
            end else begin
              stage_q[comp_q[0]] <= wdata_i;
              comp_q <= comp_q + 1'b1;
            end
          end
          SEL_MASK: mask_q <= wdata_i;
          default: ;
        endcase
      end

      if (rd_acc) begin
        rdata_q <= rd_mux;
        if (sel_i == SEL_DATA) begin
          if (last_comp) begin
            ridx_q <= ridx_q + 1'b1;
            comp_q <= '0;
          end else begin
            comp_q <= comp_q + 1'b1;
          end
        end
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign dirty_o   = dirty_q;
  assign widx_o    = widx_q;
  assign ridx_o    = ridx_q;
  assign mask_o    = mask_q;
  assign wr_mode_o = wr_mode_q;
endmodule

// File: rtl/pal_dac_pix.sv
module pal_dac_pix #(
  parameter int IDX_W = 8,
  parameter int DW    = 8,
  localparam int ENT_W = 3 * DW,
  localparam int OUT_W = 8 + ENT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] pix_idx_i,
  input  logic [DW-1:0]    mask_i,
  output logic [IDX_W-1:0] lut_idx_o,
  input  logic [ENT_W-1:0] entry_i,
  output logic [OUT_W-1:0] rgb_o
);
  logic [OUT_W-1:0] rgb_q;

  assign lut_idx_o = pix_idx_i & mask_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_q <= {8'hFF, {ENT_W{1'b0}}};
    else         rgb_q <= {8'hFF, entry_i};
  end

  assign rgb_o = rgb_q;
endmodule

// File: rtl/pal_dac.sv
module pal_dac #(
  parameter int IDX_W = 8,
  parameter int DW    = 8,
  localparam int ENT_W = 3 * DW,
  localparam int OUT_W = 8 + ENT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_en_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic [IDX_W-1:0] pix_idx_i,
  output logic [OUT_W-1:0] pix_rgb_o,
  input  logic             dirty_clr_i,
  output logic             dirty_o
);
  logic [IDX_W-1:0] widx_w, ridx_w, lut_idx_w;
  logic [DW-1:0]    mask_w;
  logic             wr_mode_w, commit_w;
  logic [ENT_W-1:0] commit_data_w, rd_entry_w, pix_entry_w;

  pal_dac_host #(.IDX_W(IDX_W), .DW(DW)) i_host (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (reg_en_i),
    .we_i          (reg_we_i),
    .sel_i         (reg_sel_i),
    .wdata_i       (reg_wdata_i),
    .rdata_o       (reg_rdata_o),
    .dirty_clr_i   (dirty_clr_i),
    .dirty_o       (dirty_o),
    .rd_entry_i    (rd_entry_w),
    .widx_o        (widx_w),
    .ridx_o        (ridx_w),
    .mask_o        (mask_w),
    .wr_mode_o     (wr_mode_w),
    .commit_o      (commit_w),
    .commit_data_o (commit_data_w)
  );

  pal_dac_table #(.IDX_W(IDX_W), .DW(DW)) i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (commit_w),
    .waddr_i   (widx_w),
    .wdata_i   (commit_data_w),
    .raddr_a_i (ridx_w),
    .rdata_a_o (rd_entry_w),
    .raddr_b_i (lut_idx_w),
    .rdata_b_o (pix_entry_w)
  );

  pal_dac_pix #(.IDX_W(IDX_W), .DW(DW)) i_pix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_idx_i (pix_idx_i),
    .mask_i    (mask_w),
    .lut_idx_o (lut_idx_w),
    .entry_i   (pix_entry_w),
    .rgb_o     (pix_rgb_o)
  );
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
  parameter int IDX_W = 8,
  parameter int DW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_en_i,
  input logic             reg_we_i,
  input logic [2:0]       reg_sel_i,
  input logic [DW-1:0]    reg_wdata_i,
  input logic [DW-1:0]    reg_rdata_o,
  input logic             dirty_clr_i,
  input logic             dirty_o,
  input logic             commit_w,
  input logic [IDX_W-1:0] widx_w,
  input logic [DW-1:0]    mask_w,
  input logic             wr_mode_w
);
  AST_WIDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && reg_we_i && reg_sel_i == 3'd0) |=> widx_w == $past(reg_wdata_i[IDX_W-1:0])); // R2
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && reg_we_i && reg_sel_i == 3'd3) |=> mask_w == $past(reg_wdata_i)); // R2
  AST_WIDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_w |=> widx_w == IDX_W'($past(widx_w) + 1'b1)); // R4
  AST_MODE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && reg_we_i && reg_sel_i == 3'd0) |=> wr_mode_w); // R7
  AST_MODE_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && reg_we_i && reg_sel_i == 3'd1) |=> !wr_mode_w); // R7
  AST_DIRTY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_w |=> dirty_o); // R9
  AST_DIRTY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dirty_clr_i && !commit_w) |=> !dirty_o); // R9
  AST_DIRTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dirty_clr_i && !commit_w) |=> $stable(dirty_o)); // R9
  AST_UNMAPPED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_en_i && !reg_we_i && reg_sel_i > 3'd4) |=> reg_rdata_o == '0); // R10
endmodule

bind pal_dac pal_dac_chk #(.IDX_W(IDX_W), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_en_i    (reg_en_i),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .dirty_clr_i (dirty_clr_i),
  .dirty_o     (dirty_o),
  .commit_w    (commit_w),
  .widx_w      (widx_w),
  .mask_w      (mask_w),
  .wr_mode_w   (wr_mode_w)
);

// File: tb/test_pal_dac.sv
module test_pal_dac;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 60;
  // {req nibble, op nibble (bit3 = write, bits2:0 = select), data/expected byte}
  localparam logic [15:0] VEC [NV] = '{
    16'h1000, 16'h1100, 16'h13FF, 16'h1400, 16'h1200,                     // R1 reset values
    16'h3805, 16'h3A11, 16'h3A22, 16'h3A33, 16'h3006,                     // R3 commit, index step
    16'h3A44, 16'h3A55, 16'h3A66, 16'h3007,                               // R3
    16'h7905, 16'h7400,                                                   // R7 read mode
    16'h5211, 16'h5222, 16'h5233, 16'h5244, 16'h5255, 16'h5266, 16'h5107, // R5 read order
    16'h2B0F, 16'h230F, 16'h2881, 16'h2081, 16'h2942, 16'h2142,           // R2 readback
    16'h48FF, 16'h4AA1, 16'h4AA2, 16'h4AA3, 16'h4000, 16'h7401,           // R4 wrap, R7
    16'h59FF, 16'h52A1, 16'h52A2, 16'h52A3, 16'h5100, 16'h7400,           // R5 wrap
    16'h6807, 16'h6A99, 16'h6A98, 16'h6807, 16'h6A01, 16'h6A02, 16'h6A03, // R6 partial write
    16'h6907, 16'h6201, 16'h6202, 16'h6203,
    16'h6905, 16'h6211, 16'h6905, 16'h6211, 16'h6222,                     // R6 read restart
    16'hAD77, 16'hA500, 16'hA30F                                          // R10 unmapped
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0, clr = 1'b0;
  logic [2:0]  sel = '0;
  logic [7:0]  wdata = '0, rdata, pidx = '0;
  logic [31:0] rgb;
  logic        dirty;
  int          tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_dac i_pal_dac (
    .clk_i(clk), .rst_ni(rst_n), .reg_en_i(en), .reg_we_i(we), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pix_idx_i(pidx), .pix_rgb_o(rgb),
    .dirty_clr_i(clr), .dirty_o(dirty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [2:0] s, input logic [7:0] d, input logic c);
    @(negedge clk);
    en = 1'b1; we = w; sel = s; wdata = d; clr = c;
    @(negedge clk);
    en = 1'b0; we = 1'b0; clr = 1'b0;
  endtask

  task automatic pix(input logic [7:0] i, input logic [31:0] exp, input string req);
    @(negedge clk);
    pidx = i;
    @(negedge clk);
    chk(req, rgb, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dirty", {31'b0, dirty}, 32'd0);
    chk("R1 pixel", rgb, 32'hFF000000);

    for (int k = 0; k < NV; k++) begin
      acc(VEC[k][11], VEC[k][10:8], VEC[k][7:0], 1'b0);
      if (!VEC[k][11])
        chk($sformatf("R%0d vec%0d", VEC[k][15:12], k), {24'b0, rdata}, {24'b0, VEC[k][7:0]});
    end

    // R8: mask 0x0F still set, one-cycle latency
    @(negedge clk);
    pidx = 8'h15;
    #1 chk("R8 latency", rgb, 32'hFF000000);
    @(negedge clk);
    chk("R8 masked", rgb, 32'hFF112233);
    pix(8'h17, 32'hFF010203, "R8 masked2");
    acc(1'b1, 3'd3, 8'hFF, 1'b0);
    pix(8'hFF, 32'hFFA1A2A3, "R8 full");
    pix(8'h06, 32'hFF445566, "R8 entry6");

    // R9
    chk("R9 set", {31'b0, dirty}, 32'd1);
    acc(1'b0, 3'd4, 8'h00, 1'b1);
    chk("R9 clear", {31'b0, dirty}, 32'd0);
    pidx = 8'h20;
    acc(1'b1, 3'd0, 8'h20, 1'b0);
    acc(1'b1, 3'd2, 8'h0C, 1'b0);
    acc(1'b1, 3'd2, 8'h0D, 1'b0);
    acc(1'b1, 3'd2, 8'h0E, 1'b1);
    chk("R9 set wins", {31'b0, dirty}, 32'd1);
    chk("R8 old during commit", rgb, 32'hFF000000);
    @(negedge clk);
    chk("R8 new after commit", rgb, 32'hFF0C0D0E);
    acc(1'b0, 3'd4, 8'h00, 1'b1);
    chk("R9 clear again", {31'b0, dirty}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule